// File: doc/BRIEF.md
# Serial Port Receive/Transmit Byte Queue Controller

This block buffers bytes between a host register interface and a simple serial receiver and transmitter. It has a receive queue and a transmit queue, each 16 bytes deep. Bytes from the receiver are queued until the host reads them. Bytes written by the host are queued and handed to the serializer one at a time over a valid/ready handshake. The block raises a receive interrupt when the number of buffered receive bytes reaches a level the host chooses. It raises a transmit interrupt when the transmit queue has drained to empty.

The host never sees a fill count. It sees whether at least one received byte is waiting, whether the transmit side still holds data, and a sticky overrun flag. The host can flush either queue, and the dropped bytes leave no record. When buffering is switched off, each direction behaves as a single-byte holding register.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: With buffering enabled (`fifo_en_i`=1), the receive queue holds up to 16 bytes and `host_rdata_o` shows the oldest one. A `host_rd_i` pulse removes that byte, so bytes leave in arrival order. A read while the queue is empty has no effect.
- R2: `rx_irq_o` is high exactly when the receive level is at or above the trigger. `rx_trig_i` encodes the trigger as 00=1, 01=4, 10=8, 11=14 bytes. The interrupt drops in the same cycle the level falls below the trigger.
- R3: A byte that arrives while the receive queue is at capacity, with no host read in the same cycle, is discarded and the queue contents are kept. `overrun_o` rises on the next cycle and stays high until a `lsr_rd_i` pulse. If a new overrun and the clear happen in the same cycle, the set wins.
- R4: While the transmit queue is not empty, `tx_valid_o` is high and `tx_data_o` holds the oldest byte. The byte is removed on a cycle with `tx_ready_i` high, so bytes go out in write order. A host write into a full transmit queue is ignored.
- R5: `tx_irq_o` rises on the cycle after the serializer accepts the last byte in the transmit queue. It is cleared by an accepted host write or by an `iir_rd_i` pulse. A same-cycle set wins over `iir_rd_i`.
- R6: `rx_avail_o` is high exactly when the receive queue is not empty. `tx_busy_o` is high exactly when the transmit queue is not empty.
- R7: A flush pulse empties its queue by the next cycle. It wins over a push and a pop in the same cycle. A byte that arrives during a receive flush is dropped without an overrun. `tx_valid_o` is low during a transmit flush.
- R8: With `fifo_en_i`=0, each queue holds one byte and the receive trigger is 1 byte, whatever `rx_trig_i` says.
- R9: A push and a pop on the same queue in one cycle leave its level unchanged. An arrival into a full receive queue during a host read is accepted without an overrun.
- R10: After reset both queues are empty and `overrun_o`, `rx_irq_o` and `tx_irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 = 16-byte queues, 0 = single-byte holding registers |
| rx_trig_i | input | 2 | Receive interrupt trigger select (00=1, 01=4, 10=8, 11=14) |
| rx_flush_i | input | 1 | Discard all receive queue contents |
| tx_flush_i | input | 1 | Discard all transmit queue contents |
| rx_valid_i | input | 1 | Receiver delivers a byte this cycle |
| rx_data_i | input | 8 | Received byte |
| host_rd_i | input | 1 | Host reads the oldest received byte |
| host_rdata_o | output | 8 | Oldest received byte |
| host_wr_i | input | 1 | Host writes a byte for transmission |
| host_wdata_i | input | 8 | Byte to transmit |
| tx_valid_o | output | 1 | A byte is offered to the serializer |
| tx_data_o | output | 8 | Byte offered to the serializer |
| tx_ready_i | input | 1 | Serializer accepts the offered byte |
| lsr_rd_i | input | 1 | Host reads line status; clears overrun |
| iir_rd_i | input | 1 | Host reads interrupt identity; clears transmit interrupt |
| rx_avail_o | output | 1 | At least one received byte is waiting |
| tx_busy_o | output | 1 | Transmit queue not empty |
| overrun_o | output | 1 | Sticky receive overrun flag |
| rx_irq_o | output | 1 | Receive level at or above trigger |
| tx_irq_o | output | 1 | Transmit queue drained empty |

## Verification
The bench fills the receive queue past capacity and then drives further arrivals. A design that overwrote stored bytes or counted a 17th byte would show the wrong head byte, or raise the overrun flag a cycle late. Arrivals into a full queue are also driven while the host reads, along with push-pop collisions on both queues. An off-by-one in the level update would make the receive interrupt and status flags drift from the model at the 1/4/8/14 thresholds. Flushes collide with pushes, pops and serializer acceptance, and single-byte mode runs with every trigger code. A wrong priority would leave stale data, raise a false transmit interrupt, or let a trigger above 1 take effect with buffering off.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned QDEPTH = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } rx_trig_e;

  function automatic int unsigned trig_bytes(input rx_trig_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_byte_queue.sv
module uart_byte_queue #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(DEPTH+1)-1:0]   cap_i,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [WIDTH-1:0]             data_i,
  output logic [WIDTH-1:0]             data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic                         push_ok_o,
  output logic                         pop_ok_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    level_q;
  logic             push_ok, pop_ok;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q >= cap_i);

  // pop first frees a slot for a same-cycle push
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign push_ok = push_i & ~flush_i & (~full_o | pop_ok);

  assign push_ok_o = push_ok;
  assign pop_ok_o  = pop_ok;
  assign data_o    = mem_q[rd_ptr_q];
  assign level_o   = level_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CW'(DEPTH));
  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0));
  assert_push_pop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && pop_ok) |=> $stable(level_q));
  assert_no_pop_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_ok) |=> empty_o);
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned WIDTH = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [1:0]       rx_trig_i,
  input  logic             rx_flush_i,
  input  logic             rx_valid_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             host_rd_i,
  input  logic             lsr_rd_i,
  output logic [WIDTH-1:0] host_rdata_o,
  output logic             rx_avail_o,
  output logic             overrun_o,
  output logic             rx_irq_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [CW-1:0] cap, trig, level;
  logic          empty, full, push_ok, pop_ok;
  logic          ovf_evt, overrun_q;

  assign cap  = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign trig = fifo_en_i ? CW'(trig_bytes(rx_trig_e'(rx_trig_i))) : CW'(1);

  uart_byte_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_rx_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .flush_i   (rx_flush_i),
    .push_i    (rx_valid_i),
    .pop_i     (host_rd_i),
    .data_i    (rx_data_i),
    .data_o    (host_rdata_o),
    .level_o   (level),
    .empty_o   (empty),
    .full_o    (full),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok)
  );

  // arrival into a full queue with no read to make room
  assign ovf_evt = rx_valid_i & ~rx_flush_i & full & ~pop_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       overrun_q <= 1'b0;
    else if (ovf_evt)  overrun_q <= 1'b1;
    else if (lsr_rd_i) overrun_q <= 1'b0;
  end

  assign rx_avail_o = ~empty;
  assign overrun_o  = overrun_q;
  assign rx_irq_o   = (level >= trig);

  assert_overrun_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> overrun_q);
  assert_overrun_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> $stable(level));
  assert_overrun_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_q && !lsr_rd_i) |=> overrun_q);
  assert_full_read_accepts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && full && pop_ok) |-> push_ok);
  always_comb begin
    assert_irq_needs_data_R2: assert (!rst_ni || !rx_irq_o || !empty);
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned WIDTH = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             tx_flush_i,
  input  logic             host_wr_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  input  logic             iir_rd_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [WIDTH-1:0] tx_data_o,
  output logic             tx_busy_o,
  output logic             tx_irq_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [CW-1:0] cap, level;
  logic          empty, full, push_ok, pop_ok;
  logic          drain_evt, tx_irq_q;

  assign cap = fifo_en_i ? CW'(DEPTH) : CW'(1);

  uart_byte_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_tx_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .flush_i   (tx_flush_i),
    .push_i    (host_wr_i),
    .pop_i     (tx_ready_i),
    .data_i    (host_wdata_i),
    .data_o    (tx_data_o),
    .level_o   (level),
    .empty_o   (empty),
    .full_o    (full),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok)
  );

  // last byte leaves and nothing replaces it
  assign drain_evt = pop_ok & ~push_ok & (level == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tx_irq_q <= 1'b0;
    else if (drain_evt)            tx_irq_q <= 1'b1;
    else if (push_ok || iir_rd_i)  tx_irq_q <= 1'b0;
  end

  assign tx_valid_o = ~empty & ~tx_flush_i;
  assign tx_busy_o  = ~empty;
  assign tx_irq_o   = tx_irq_q;

  assert_irq_on_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_evt |=> tx_irq_q);
  assert_irq_only_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_q |-> empty);
  assert_full_rejects_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && full && !pop_ok) |-> !push_ok);
  assert_pop_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok |-> tx_valid_o);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned WIDTH = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [1:0]       rx_trig_i,
  input  logic             rx_flush_i,
  input  logic             tx_flush_i,
  input  logic             rx_valid_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             host_rd_i,
  output logic [WIDTH-1:0] host_rdata_o,
  input  logic             host_wr_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  output logic             tx_valid_o,
  output logic [WIDTH-1:0] tx_data_o,
  input  logic             tx_ready_i,
  input  logic             lsr_rd_i,
  input  logic             iir_rd_i,
  output logic             rx_avail_o,
  output logic             tx_busy_o,
  output logic             overrun_o,
  output logic             rx_irq_o,
  output logic             tx_irq_o
);
  uart_rx_path #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rx_path (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_en_i    (fifo_en_i),
    .rx_trig_i    (rx_trig_i),
    .rx_flush_i   (rx_flush_i),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .host_rd_i    (host_rd_i),
    .lsr_rd_i     (lsr_rd_i),
    .host_rdata_o (host_rdata_o),
    .rx_avail_o   (rx_avail_o),
    .overrun_o    (overrun_o),
    .rx_irq_o     (rx_irq_o)
  );

  uart_tx_path #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_tx_path (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_en_i    (fifo_en_i),
    .tx_flush_i   (tx_flush_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .iir_rd_i     (iir_rd_i),
    .tx_ready_i   (tx_ready_i),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .tx_busy_o    (tx_busy_o),
    .tx_irq_o     (tx_irq_o)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!overrun_o && !tx_irq_o));
endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [1:0] trig = 2'b00;
  logic rxf = 1'b0, txf = 1'b0, rxv = 1'b0, rd = 1'b0, wr = 1'b0, rdy = 1'b0;
  logic lsr = 1'b0, iir = 1'b0;
  logic [7:0] rxd = '0, wd = '0;
  logic [7:0] rdata, txd;
  logic txv, avail, busy, ovr, rirq, tirq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R10";

  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit m_ovr = 1'b0;
  bit m_tirq = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(en), .rx_trig_i(trig),
    .rx_flush_i(rxf), .tx_flush_i(txf), .rx_valid_i(rxv), .rx_data_i(rxd),
    .host_rd_i(rd), .host_rdata_o(rdata), .host_wr_i(wr), .host_wdata_i(wd),
    .tx_valid_o(txv), .tx_data_o(txd), .tx_ready_i(rdy), .lsr_rd_i(lsr),
    .iir_rd_i(iir), .rx_avail_o(avail), .tx_busy_o(busy), .overrun_o(ovr),
    .rx_irq_o(rirq), .tx_irq_o(tirq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s %s actual %0d expected %0d at cycle %0d", req, tag, what, act, exp, cycles);
    end
  endtask

  function automatic int trig_lvl();
    if (!en) return 1;
    case (trig)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  task automatic compare();
    chk("R6", "rx_avail", avail, rxq.size() > 0);
    chk("R6", "tx_busy", busy, txq.size() > 0);
    if (rxq.size() > 0) chk("R1", "host_rdata", rdata, rxq[0]);
    chk("R2", "rx_irq", rirq, rxq.size() >= trig_lvl());
    chk("R3", "overrun", ovr, m_ovr);
    chk("R4", "tx_valid", txv, (txq.size() > 0) && !txf);
    if (txq.size() > 0) chk("R4", "tx_data", txd, txq[0]);
    chk("R5", "tx_irq", tirq, m_tirq);
  endtask

  task automatic model_step();
    int cap;
    bit pop, push, ovf, drain;
    cap = en ? 16 : 1;
    ovf = 1'b0;
    if (rxf) rxq.delete();
    else begin
      pop = rd && rxq.size() > 0;
      ovf = rxv && (rxq.size() >= cap) && !pop;
      if (pop) void'(rxq.pop_front());
      if (rxv && !ovf) rxq.push_back(rxd);
    end
    if (ovf) m_ovr = 1'b1;
    else if (lsr) m_ovr = 1'b0;
    drain = 1'b0;
    push = 1'b0;
    if (txf) txq.delete();
    else begin
      pop = rdy && txq.size() > 0;
      push = wr && (txq.size() < cap || pop);
      drain = pop && !push && txq.size() == 1;
      if (pop) void'(txq.pop_front());
      if (push) txq.push_back(wd);
    end
    if (drain) m_tirq = 1'b1;
    else if (push || iir) m_tirq = 1'b0;
  endtask

  task automatic tick();
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic run(input int n, input string t, input bit e, input int p_rxv,
                     input int p_rd, input int p_wr, input int p_rdy,
                     input int p_fl, input int p_clr);
    tag = t;
    for (int i = 0; i < n; i++) begin
      en   = e;
      trig = 2'($urandom % 4);
      rxv  = pct(p_rxv);
      rxd  = 8'($urandom);
      rd   = pct(p_rd);
      wr   = pct(p_wr);
      wd   = 8'($urandom);
      rdy  = pct(p_rdy);
      rxf  = pct(p_fl);
      txf  = pct(p_fl);
      lsr  = pct(p_clr);
      iir  = pct(p_clr);
      tick();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "rx_avail", avail, 0);
    chk("R10", "tx_busy", busy, 0);
    chk("R10", "overrun", ovr, 0);
    chk("R10", "rx_irq", rirq, 0);
    chk("R10", "tx_irq", tirq, 0);
    chk("R10", "tx_valid", txv, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(20, "R1", 1, 90, 0, 0, 0, 0, 0);
    run(10, "R3", 1, 100, 0, 0, 0, 0, 0);
    run(4, "R3", 1, 100, 0, 0, 0, 0, 100);
    run(12, "R9", 1, 100, 100, 0, 0, 0, 0);
    run(30, "R1", 1, 0, 100, 0, 0, 0, 0);
    run(25, "R4", 1, 0, 0, 100, 0, 0, 0);
    run(40, "R5", 1, 0, 0, 0, 100, 0, 0);
    run(5, "R5", 1, 0, 0, 0, 0, 0, 100);
    run(400, "R7", 1, 60, 40, 60, 40, 15, 10);
    run(400, "R8", 0, 50, 50, 50, 50, 2, 20);
    run(2000, "R9", 1, 50, 45, 50, 45, 1, 10);
    run(300, "R2", 1, 70, 30, 60, 30, 1, 10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule